// File: doc/BRIEF.md
# Comma-Aligning Serial-to-Word Receiver with Split Byte Clocks

This block is the receive half of a 10-bit serializer/deserializer, modelled one bit per clock. Every bit-clock cycle it takes one recovered bit, drawn either from the line input or from the internal loopback path according to the wrap control. It packs the bits into 10-bit words, least significant bit first. When alignment is enabled it watches for a 7-bit comma prefix at every bit offset and restarts the word boundary so that the comma opens a new word. Each word is handed out together with a comma flag and two opposite-phase byte clocks, each running at half the word rate. Words are launched alternately on their rising edges, and a comma word always rises with byte clock 1.

The byte clocks come from a four-state machine. `BC_IDLE` holds both clocks low after reset. `BC_PH1` holds byte clock 1 high. `BC_PH0` holds byte clock 0 high. `BC_RESYNC` holds both clocks low for one bit cycle. On a normal word launch the machine moves from `BC_PH1` to `BC_PH0`, and from `BC_IDLE` or `BC_PH0` to `BC_PH1`. On a comma word launch it moves from `BC_IDLE` or `BC_PH0` to `BC_PH1`, and from `BC_PH1` to `BC_RESYNC`. `BC_RESYNC` always passes to `BC_PH1` on the next cycle, which stretches byte clock 1 so that it can rise again for the comma word. A loss-of-signal input forces all ten data outputs high.

Top module: `dsr_comma_deser`

## Requirements
- R1: During and right after reset, word_out is all ones, comma_flag is low and both byte clocks are low.
- R2: The first received bit of a word appears at word_out[0]. With alignment off, a new word is launched every 10 bit cycles, counted from reset, and it appears after the clock edge that samples its tenth bit.
- R3: With align_en high, a word is launched at the bit cycle in which the ten most recent bits hold the comma prefix. The prefix is the oldest seven bits, received in the order 0,0,1,1,1,1,1, so that word[6:0] = 7'b1111100. This holds at any bit offset, and comma_flag is high for that word. The next word boundary is then counted from that point.
- R4: With align_en low, the word boundary never moves and comma_flag is low from the cycle after align_en is sampled low.
- R5: The two byte clocks are never high together. Each normal word launch raises the clock that was low, and the first word after reset raises byte clock 1.
- R6: A comma word is launched with a rising edge of byte clock 1. If byte clock 1 is already high, both clocks go low for one bit cycle and byte clock 1 then rises.
- R7: While sig_lost is sampled high, word_out is all ones in the following cycle.
- R8: With wrap_en high, bits are taken from loop_bit; otherwise they are taken from line_bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_bit | input | 1 | Serial bit from the line |
| loop_bit | input | 1 | Serial bit from the loopback path |
| wrap_en | input | 1 | Selects loop_bit when high |
| align_en | input | 1 | Enables comma search and realignment |
| sig_lost | input | 1 | Loss of input signal; forces data high |
| word_out | output | 10 | Received word, bit 0 received first |
| comma_flag | output | 1 | High for a word holding the comma |
| bclk0 | output | 1 | Byte clock 0, half word rate |
| bclk1 | output | 1 | Byte clock 1, opposite phase; rises with comma words |

## Verification
Comma detection and the normal ten-bit count boundary can fall in the same bit cycle. The bench provokes this by sending two comma words back to back, so the second prefix completes exactly when the counter reaches its last position. The cycle-accurate model judges it: only one word may be launched, flagged as a comma, and the byte clocks may change state once. Because the first comma left byte clock 1 high, this also drives the `BC_RESYNC` path. A realignment that coincides with loss of signal is also exercised: the data must read all ones while the clocks still follow the comma.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    typedef enum logic [1:0] {
        BC_IDLE   = 2'd0,
        BC_PH0    = 2'd1,
        BC_PH1    = 2'd2,
        BC_RESYNC = 2'd3
    } bc_state_t;
endpackage

// File: rtl/dsr_window.sv
module dsr_window #(
    parameter int W = 10,
    parameter int PL = 7,
    parameter logic [PL-1:0] PFX = 7'b1111100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_bit,
    input  logic         loop_bit,
    input  logic         wrap_en,
    input  logic         align_en,
    output logic [W-1:0] win_next,
    output logic         hit
);
    logic [W-1:0]  win_q;
    logic          sel_bit;
    logic [PL-1:0] match;

    assign sel_bit  = wrap_en ? loop_bit : line_bit;
    assign win_next = {sel_bit, win_q[W-1:1]};

    // window resets to ones so no prefix can match before ten real bits
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= win_next;
    end

    for (genvar i = 0; i < PL; i++) begin : g_cmp
        assign match[i] = (win_next[i] == PFX[i]);
    end

    assign hit = align_en && (&match);
endmodule

// File: rtl/dsr_framer.sv
module dsr_framer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] win_next,
    input  logic         hit,
    input  logic         align_en,
    input  logic         sig_lost,
    output logic [W-1:0] word_q,
    output logic         flag_q,
    output logic         launch,
    output logic         launch_comma
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;

    assign launch       = hit || (cnt_q == LAST);
    assign launch_comma = hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '1;
            flag_q <= 1'b0;
        end else begin
            cnt_q <= launch ? '0 : cnt_q + 1'b1;
            if (sig_lost)    word_q <= '1;
            else if (launch) word_q <= win_next;
            if (!align_en)   flag_q <= 1'b0;
            else if (launch) flag_q <= hit;
        end
    end
endmodule

// File: rtl/dsr_byteclk.sv
module dsr_byteclk
    import dsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic launch_comma,
    output logic bclk0,
    output logic bclk1
);
    bc_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BC_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BC_IDLE:   if (launch) st_d = BC_PH1;
            BC_PH0:    if (launch) st_d = BC_PH1;
            BC_PH1:    if (launch) st_d = launch_comma ? BC_RESYNC : BC_PH0;
            BC_RESYNC: st_d = BC_PH1;
            default:   st_d = BC_IDLE;
        endcase
    end

    always_comb begin
        bclk0 = 1'b0;
        bclk1 = 1'b0;
        unique case (st_q)
            BC_PH0:  bclk0 = 1'b1;
            BC_PH1:  bclk1 = 1'b1;
            default: begin
                bclk0 = 1'b0;
                bclk1 = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dsr_comma_deser.sv
module dsr_comma_deser #(
    parameter int W = 10,
    parameter int PL = 7,
    parameter logic [PL-1:0] PFX = 7'b1111100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_bit,
    input  logic         loop_bit,
    input  logic         wrap_en,
    input  logic         align_en,
    input  logic         sig_lost,
    output logic [W-1:0] word_out,
    output logic         comma_flag,
    output logic         bclk0,
    output logic         bclk1
);
    logic [W-1:0] win_next;
    logic         hit;
    logic         launch;
    logic         launch_comma;

    dsr_window #(.W(W), .PL(PL), .PFX(PFX)) u_win (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .loop_bit(loop_bit),
        .wrap_en(wrap_en), .align_en(align_en), .win_next(win_next), .hit(hit)
    );

    dsr_framer #(.W(W)) u_frm (
        .clk(clk), .rst_n(rst_n), .win_next(win_next), .hit(hit),
        .align_en(align_en), .sig_lost(sig_lost), .word_q(word_out),
        .flag_q(comma_flag), .launch(launch), .launch_comma(launch_comma)
    );

    dsr_byteclk u_bclk (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_comma(launch_comma),
        .bclk0(bclk0), .bclk1(bclk1)
    );
endmodule

// File: rtl/dsr_comma_deser_chk.sv
module dsr_comma_deser_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         align_en,
    input logic         sig_lost,
    input logic [W-1:0] word_out,
    input logic         comma_flag,
    input logic         bclk0,
    input logic         bclk1
);
    p_clk_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk0 && bclk1));

    p_rise0_after1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk0) |-> $past(bclk1));

    p_comma_not_b0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk0) |-> !comma_flag);

    p_resync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk0 && !bclk1 && comma_flag) |=> bclk1);

    p_flag_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en |=> !comma_flag);

    p_lost_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sig_lost |=> (word_out == {W{1'b1}}));
endmodule

bind dsr_comma_deser dsr_comma_deser_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .sig_lost(sig_lost),
    .word_out(word_out), .comma_flag(comma_flag), .bclk0(bclk0), .bclk1(bclk1)
);

// File: tb/dsr_comma_deser_tb_top.sv
`timescale 1ns/1ps
module dsr_comma_deser_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_bit = 1'b0, loop_bit = 1'b0;
    logic       wrap_en = 1'b0, align_en = 1'b0, sig_lost = 1'b0;
    logic [9:0] word_out;
    logic       comma_flag, bclk0, bclk1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int     hist[$];
    int     m_cnt, m_st;
    logic [9:0] m_word;
    logic   m_flag;
    logic [15:0] lfsr = 16'hACE1;
    string  tag = "R1";

    localparam logic [9:0] COMMA = 10'h17C;

    always #2.5 clk = ~clk;

    dsr_comma_deser dut_i (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .loop_bit(loop_bit),
        .wrap_en(wrap_en), .align_en(align_en), .sig_lost(sig_lost),
        .word_out(word_out), .comma_flag(comma_flag), .bclk0(bclk0), .bclk1(bclk1)
    );

    task automatic model_reset();
        hist.delete();
        for (int i = 0; i < 10; i++) hist.push_back(1);
        m_cnt = 0; m_st = 0; m_word = '1; m_flag = 1'b0;
    endtask

    task automatic model_step(input logic b);
        bit hit, emit;
        void'(hist.pop_front());
        hist.push_back(int'(b));
        hit = align_en && hist[0] == 0 && hist[1] == 0 && hist[2] == 1 &&
              hist[3] == 1 && hist[4] == 1 && hist[5] == 1 && hist[6] == 1;
        emit = hit || (m_cnt == 9);
        m_cnt = emit ? 0 : m_cnt + 1;
        if (sig_lost) m_word = '1;
        else if (emit) for (int i = 0; i < 10; i++) m_word[i] = hist[i][0];
        if (!align_en) m_flag = 1'b0;
        else if (emit) m_flag = hit;
        if (emit) begin
            if (hit) m_st = (m_st == 2) ? 3 : 2;
            else     m_st = (m_st == 2) ? 1 : 2;
        end else if (m_st == 3) m_st = 2;
    endtask

    task automatic compare();
        checks++;
        if (word_out !== m_word) begin
            errors++;
            $display("FAIL %s word: actual=%h expected=%h", tag, word_out, m_word);
        end
        checks++;
        if (comma_flag !== m_flag) begin
            errors++;
            $display("FAIL R3 R4 (%s) flag: actual=%b expected=%b", tag, comma_flag, m_flag);
        end
        checks++;
        if (bclk0 !== (m_st == 1) || bclk1 !== (m_st == 2)) begin
            errors++;
            $display("FAIL R5 R6 (%s) clocks: actual=%b%b expected=%b%b",
                     tag, bclk1, bclk0, m_st == 2, m_st == 1);
        end
    endtask

    // the selected input carries b; the other input carries its inverse (R8)
    task automatic tick(input logic b);
        line_bit = wrap_en ? ~b : b;
        loop_bit = wrap_en ? b : ~b;
        model_step(b);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) tick(w[i]);
    endtask

    task automatic send_rand(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(lfsr[0]);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;
        compare();

        tag = "R2 R4";
        align_en = 1'b0;
        send_rand(40);
        send_rand(3);
        send_word(COMMA);
        send_rand(25);

        tag = "R3 R6";
        align_en = 1'b1;
        send_rand(4);
        send_word(COMMA);
        send_word(COMMA);
        send_word(COMMA);
        send_rand(17);
        send_word(COMMA);
        send_rand(30);

        tag = "R4";
        align_en = 1'b0;
        send_rand(2);
        send_word(COMMA);
        send_rand(12);

        tag = "R8";
        align_en = 1'b1;
        wrap_en = 1'b1;
        send_rand(6);
        send_word(COMMA);
        send_rand(30);
        wrap_en = 1'b0;
        send_rand(20);

        tag = "R7";
        sig_lost = 1'b1;
        send_rand(5);
        send_word(COMMA);
        send_rand(8);
        sig_lost = 1'b0;
        send_rand(30);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule